// File: doc/BRIEF.md
# Oversampled Serial Receiver with Standby Wakeup

This block receives asynchronous serial characters. It runs on a receive-timing tick enable (`rt_tick`) that pulses sixteen times per bit period. A falling edge on the idle-high line starts a frame. The block then steps through the start bit, 8 or 9 data bits (least significant bit first) and one stop bit. Three samples, taken at ticks 8, 9 and 10 of each bit, decide the value of that bit by majority.

Because sampling is centred and finishes at tick 10 of the stop bit, the receiver accepts a transmitter that runs fast. The allowed skew is a frame squeezed into 154 ticks (8-bit characters) or 170 ticks (9-bit characters) instead of 160 or 176.

A standby state lets the receiver ignore traffic that is not meant for it. In standby, characters are still decoded but none is announced. Standby ends in one of two ways, chosen by `wake_sel`:
- a full character time of continuous idle line (idle-line wakeup), or
- a character whose top data bit is set, which is then delivered (address-mark wakeup).

Wakeup, and therefore standby, is unavailable while smart-card mode is on.

Top module: `uart_wake_rx`

## Requirements
- R1: After synchronous reset, `rx_valid`, `in_standby`, `frame_err`, `noise_err` and `rx_data` are all 0.
- R2: With `nine_bit`=0, a frame carries 8 data bits, first received bit in `rx_data[0]`, with `rx_data[8]`=0. `rx_valid` is high for exactly one clock, set by the tick that is the 154th tick counting the start-detect tick as the first.
- R3: With `nine_bit`=1, a frame carries 9 data bits in `rx_data[8:0]`, and `rx_valid` is set by the 170th tick of the frame.
- R4: Each bit value is the majority of its samples at ticks 8, 9 and 10. A character in which any data or stop bit has disagreeing samples is delivered with `noise_err`=1. A single wrong sample does not change the bit value.
- R5: A start is accepted only if all three start-bit samples are low. Otherwise no character is produced, and the receiver waits for a new falling edge.
- R6: A stop bit whose majority is 0 sets `frame_err`=1, and the character is still delivered with `rx_valid`.
- R7: A frame whose bit edges are spread evenly over 154 ticks (8-bit) or 170 ticks (9-bit) is received correctly without `frame_err`. A start bit that follows it immediately is also received.
- R8: A one-clock `standby_req` with `smartcard_en`=0 sets `in_standby` at the next clock edge. While `in_standby`=1, received characters produce no `rx_valid`.
- R9: With `wake_sel`=0, `in_standby` clears on the tick that completes 160 (8-bit) or 176 (9-bit) consecutive high ticks counted from the last `standby_req`. Characters received in standby do not end it.
- R10: With `wake_sel`=1, standby ends only on a character whose top data bit (bit 7 for 8-bit, bit 8 for 9-bit) is 1. That character is delivered with `rx_valid`. Characters with that bit 0, and long idle periods, leave standby in place.
- R11: While `smartcard_en`=1, `standby_req` is ignored, and `in_standby` is 0 from the clock after `smartcard_en` is seen high. Characters are delivered normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rt_tick | input | 1 | Receive-timing tick enable, 16 per bit |
| rxd | input | 1 | Serial line, already synchronized, idle high |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wake_sel | input | 1 | 0 idle-line wakeup, 1 address-mark wakeup |
| standby_req | input | 1 | Request to enter standby |
| smartcard_en | input | 1 | Smart-card mode; blocks standby |
| rx_data | output | 9 | Last delivered character |
| rx_valid | output | 1 | One-clock strobe for a delivered character |
| frame_err | output | 1 | Stop bit read as 0 for the delivered character |
| noise_err | output | 1 | Disagreeing samples in the delivered character |
| in_standby | output | 1 | Receiver is in standby |

## Verification
The character outputs register the decision made on the stop bit's tenth tick. They are therefore visible one clock after that tick's edge, which falls on frame tick 154 or 170. The bench counts ticks from the start-detect tick and compares the tick number recorded at the strobe against those values. Standby changes also appear one clock after the deciding edge: the request clock, the completing idle tick, the address character's final tick, or the first clock of smart-card mode. The bench samples `in_standby` on the falling clock edge after each of those ticks or clocks, and checks both the tick just before the change and the tick that makes it.

// File: rtl/uart_wake_rx_pkg.sv
package uart_wake_rx_pkg;

    localparam int CHAR_BITS_MAX = 9;

    typedef enum logic {
        WAKE_ON_IDLE = 1'b0,
        WAKE_ON_ADDR = 1'b1
    } wake_mode_e;

    typedef struct packed {
        logic [CHAR_BITS_MAX-1:0] data;
        logic                     frame_err;
        logic                     noise;
    } rx_char_t;

    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

    function automatic logic split3(input logic [2:0] s);
        return (s != 3'b000) && (s != 3'b111);
    endfunction

endpackage

// File: rtl/uart_rx_vote.sv
module uart_rx_vote (
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  logic       rxd,
    output logic [2:0] triple
);
    logic [1:0] held;

    always_ff @(posedge clk) begin
        if (rst) held <= 2'b00;
        else if (take) held <= {held[0], rxd};
    end

    assign triple = {held, rxd};
endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer
    import uart_wake_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     rxd,
    input  logic     nine_bit,
    output logic     done,
    output rx_char_t result
);
    localparam int PW = $clog2(OVS) + 1;
    localparam logic [PW-1:0] RT_FIRST = PW'(OVS / 2);
    localparam logic [PW-1:0] RT_LAST  = PW'(OVS / 2 + 2);
    localparam logic [PW-1:0] RT_END   = PW'(OVS);

    logic          busy, prev_hi, noise_acc;
    logic [PW-1:0] rt, rt_now;
    logic [3:0]    bit_idx, last_idx;
    logic [CHAR_BITS_MAX-1:0] shreg;
    logic [2:0]    triple;
    logic          take, at_vote, v, d;

    assign rt_now   = (rt == RT_END) ? PW'(1) : rt + PW'(1);
    assign last_idx = nine_bit ? 4'd10 : 4'd9;
    assign take     = busy & tick & (rt_now >= RT_FIRST) & (rt_now < RT_LAST);
    assign at_vote  = busy & tick & (rt_now == RT_LAST);
    assign v        = vote3(triple);
    assign d        = split3(triple);

    uart_rx_vote u_vote (
        .clk   (clk),
        .rst   (rst),
        .take  (take),
        .rxd   (rxd),
        .triple(triple)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            prev_hi   <= 1'b0;
            noise_acc <= 1'b0;
            rt        <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
        end else if (tick) begin
            prev_hi <= rxd;
            if (!busy) begin
                if (prev_hi && !rxd) begin
                    busy      <= 1'b1;
                    rt        <= PW'(1);
                    bit_idx   <= '0;
                    noise_acc <= 1'b0;
                    shreg     <= '0;
                end
            end else begin
                rt <= rt_now;
                if (rt_now == RT_END) bit_idx <= bit_idx + 4'd1;
                if (at_vote) begin
                    if (bit_idx == 4'd0) begin
                        if (triple != 3'b000) busy <= 1'b0;
                    end else if (bit_idx == last_idx) begin
                        busy <= 1'b0;
                    end else begin
                        for (int i = 0; i < CHAR_BITS_MAX; i++)
                            if (bit_idx == 4'(i + 1)) shreg[i] <= v;
                        noise_acc <= noise_acc | d;
                    end
                end
            end
        end
    end

    assign done             = at_vote & (bit_idx == last_idx);
    assign result.data      = nine_bit ? shreg : {1'b0, shreg[7:0]};
    assign result.frame_err = ~v;
    assign result.noise     = noise_acc | d;

    // R2
    bit_idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (bit_idx <= 4'd10));

    // R2
    rt_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rt >= PW'(1) && rt <= RT_END));
endmodule

// File: rtl/uart_rx_wake.sv
module uart_rx_wake
    import uart_wake_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rxd,
    input  logic       nine_bit,
    input  wake_mode_e wake_mode,
    input  logic       standby_req,
    input  logic       smartcard_en,
    input  logic       done,
    input  logic       msb,
    output logic       standby,
    output logic       deliver
);
    localparam int CW = $clog2(11 * OVS + 1);
    localparam logic [CW-1:0] IDLE8 = CW'(10 * OVS - 1);
    localparam logic [CW-1:0] IDLE9 = CW'(11 * OVS - 1);

    logic [CW-1:0] idle_cnt, idle_lim;
    logic          idle_hit, addr_hit;

    assign idle_lim = nine_bit ? IDLE9 : IDLE8;
    assign idle_hit = standby & (wake_mode == WAKE_ON_IDLE) & tick & rxd
                      & (idle_cnt == idle_lim);
    assign addr_hit = standby & (wake_mode == WAKE_ON_ADDR) & done & msb;
    assign deliver  = done & (~standby | addr_hit);

    always_ff @(posedge clk) begin
        if (rst) begin
            standby  <= 1'b0;
            idle_cnt <= '0;
        end else begin
            if (smartcard_en)              standby <= 1'b0;
            else if (standby_req)          standby <= 1'b1;
            else if (idle_hit || addr_hit) standby <= 1'b0;

            if (standby_req || !standby) idle_cnt <= '0;
            else if (tick) begin
                if (!rxd) idle_cnt <= '0;
                else if (idle_cnt != IDLE9) idle_cnt <= idle_cnt + CW'(1);
            end
        end
    end

    // R11
    standby_sc_chk: assert property (@(posedge clk) disable iff (rst)
        smartcard_en |=> !standby);

    // R8
    standby_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(standby) |-> $past(standby_req));
endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
    import uart_wake_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rt_tick,
    input  logic       rxd,
    input  logic       nine_bit,
    input  logic       wake_sel,
    input  logic       standby_req,
    input  logic       smartcard_en,
    output logic [8:0] rx_data,
    output logic       rx_valid,
    output logic       frame_err,
    output logic       noise_err,
    output logic       in_standby
);
    rx_char_t   ch;
    logic       done, deliver, msb;
    wake_mode_e wmode;

    assign wmode = wake_mode_e'(wake_sel);
    assign msb   = nine_bit ? ch.data[8] : ch.data[7];

    uart_rx_framer #(.OVS(OVS)) u_framer (
        .clk     (clk),
        .rst     (rst),
        .tick    (rt_tick),
        .rxd     (rxd),
        .nine_bit(nine_bit),
        .done    (done),
        .result  (ch)
    );

    uart_rx_wake #(.OVS(OVS)) u_wake (
        .clk         (clk),
        .rst         (rst),
        .tick        (rt_tick),
        .rxd         (rxd),
        .nine_bit    (nine_bit),
        .wake_mode   (wmode),
        .standby_req (standby_req),
        .smartcard_en(smartcard_en),
        .done        (done),
        .msb         (msb),
        .standby     (in_standby),
        .deliver     (deliver)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid  <= 1'b0;
            rx_data   <= '0;
            frame_err <= 1'b0;
            noise_err <= 1'b0;
        end else begin
            rx_valid <= deliver;
            if (deliver) begin
                rx_data   <= ch.data;
                frame_err <= ch.frame_err;
                noise_err <= ch.noise;
            end
        end
    end

    // R8
    valid_standby_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (!in_standby || $past(standby_req)));

    // R2
    valid_tick_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(rt_tick));

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);
endmodule

// File: tb/uart_wake_rx_bench.sv
`timescale 1ns/1ps
module uart_wake_rx_bench;
    logic clk = 1'b0, rst = 1'b1, rt_tick = 1'b0, rxd = 1'b1;
    logic nine_bit = 1'b0, wake_sel = 1'b0, standby_req = 1'b0, smartcard_en = 1'b0;
    logic [8:0] rx_data;
    logic rx_valid, frame_err, noise_err, in_standby;

    int n_tests = 0, n_fail = 0;
    int tick_no = 0, vcount = 0, v_tick = 0, s_tick = 0;
    logic [8:0] v_data = '0;
    logic v_fe = 1'b0, v_ne = 1'b0;

    always #2.5 clk = ~clk;

    uart_wake_rx u_uart_wake_rx (
        .clk(clk), .rst(rst), .rt_tick(rt_tick), .rxd(rxd), .nine_bit(nine_bit),
        .wake_sel(wake_sel), .standby_req(standby_req), .smartcard_en(smartcard_en),
        .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err),
        .noise_err(noise_err), .in_standby(in_standby)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            vcount++;
            v_data = rx_data;
            v_fe   = frame_err;
            v_ne   = noise_err;
            v_tick = tick_no;
        end
    end

    // nine[16] data[15:7] glitch_bit[6:3] stop[2] exp_fe[1] exp_ne[0]
    localparam logic [16:0] VEC [0:5] = '{
        {1'b0, 9'h0A5, 4'hF, 1'b1, 1'b0, 1'b0},
        {1'b1, 9'h15A, 4'hF, 1'b1, 1'b0, 1'b0},
        {1'b0, 9'h03C, 4'd3, 1'b1, 1'b0, 1'b1},
        {1'b1, 9'h1FF, 4'd10, 1'b1, 1'b0, 1'b1},
        {1'b0, 9'h055, 4'hF, 1'b0, 1'b1, 1'b0},
        {1'b1, 9'h000, 4'd1, 1'b0, 1'b1, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic v);
        @(negedge clk);
        rxd = v;
        rt_tick = 1'b1;
        @(posedge clk);
        tick_no++;
        @(negedge clk);
        rt_tick = 1'b0;
        @(posedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(1'b1);
    endtask

    task automatic send_frame(input logic nine, input logic [8:0] data,
                              input logic stop, input int gl);
        int nb;
        logic v;
        nb = nine ? 9 : 8;
        for (int k = 0; k <= nb + 1; k++) begin
            v = (k == 0) ? 1'b0 : (k <= nb) ? data[k-1] : stop;
            for (int r = 1; r <= 16; r++) begin
                tick(v ^ ((k == gl) && (r == 9)));
                if (k == 0 && r == 1) s_tick = tick_no;
            end
        end
        idle(4);
    endtask

    task automatic send_fast(input logic nine, input logic [8:0] data);
        int nb, tot, k;
        logic v;
        nb  = nine ? 9 : 8;
        tot = nine ? 170 : 154;
        for (int n = 1; n <= tot; n++) begin
            k = 0;
            while (n > ((k + 1) * tot) / (nb + 2)) k++;
            v = (k == 0) ? 1'b0 : (k <= nb) ? data[k-1] : 1'b1;
            tick(v);
            if (n == 1) s_tick = tick_no;
        end
    endtask

    task automatic pulse_req();
        @(negedge clk);
        standby_req = 1'b1;
        @(negedge clk);
        standby_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int v0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(rx_valid == 0 && in_standby == 0 && frame_err == 0 && noise_err == 0
            && rx_data == 0, "R1", {rx_valid, in_standby, frame_err, noise_err}, 0);
        rst = 1'b0;
        idle(4);

        // R2 R3 R4 R6 table walk
        for (int i = 0; i < 6; i++) begin
            nine_bit = VEC[i][16];
            v0 = vcount;
            send_frame(VEC[i][16], VEC[i][15:7], VEC[i][2], int'(VEC[i][6:3]));
            chk(vcount == v0 + 1, "R2 valid count", vcount - v0, 1);
            chk(v_data == VEC[i][15:7], VEC[i][16] ? "R3 data" : "R2 data",
                v_data, VEC[i][15:7]);
            chk(v_tick - s_tick == (VEC[i][16] ? 169 : 153),
                VEC[i][16] ? "R3 timing" : "R2 timing", v_tick - s_tick,
                VEC[i][16] ? 169 : 153);
            chk(v_fe == VEC[i][1], "R6 frame_err", v_fe, VEC[i][1]);
            chk(v_ne == VEC[i][0], "R4 noise", v_ne, VEC[i][0]);
        end

        // R5 short low pulse, then start bit with a high sample at RT9
        nine_bit = 1'b0;
        v0 = vcount;
        tick(0); tick(0); tick(0);
        idle(30);
        for (int r = 1; r <= 16; r++) tick(r == 9 || r > 10);
        idle(160);
        chk(vcount == v0, "R5 rejected start", vcount - v0, 0);
        send_frame(1'b0, 9'h05A, 1'b1, 15);
        chk(vcount == v0 + 1 && v_data == 9'h05A, "R5 recovery", v_data, 9'h05A);

        // R7 fast frames, each followed at once by a normal one
        for (int m = 0; m < 2; m++) begin
            nine_bit = m[0];
            v0 = vcount;
            send_fast(m[0], m[0] ? 9'h1E1 : 9'h0C3);
            chk(vcount == v0 + 1 && v_fe == 0, "R7 fast frame", {v_fe, v_data},
                m[0] ? 9'h1E1 : 9'h0C3);
            chk(v_data == (m[0] ? 9'h1E1 : 9'h0C3), "R7 fast data", v_data,
                m[0] ? 9'h1E1 : 9'h0C3);
            send_frame(m[0], m[0] ? 9'h0F0 : 9'h03A, 1'b1, 15);
            chk(vcount == v0 + 2 && v_data == (m[0] ? 9'h0F0 : 9'h03A),
                "R7 back to back", v_data, m[0] ? 9'h0F0 : 9'h03A);
        end

        // R8 R9 idle-line wakeup, 8-bit
        nine_bit = 1'b0;
        wake_sel = 1'b0;
        pulse_req();
        chk(in_standby == 1, "R8 entry", in_standby, 1);
        v0 = vcount;
        send_frame(1'b0, 9'h080, 1'b1, 15);
        chk(vcount == v0, "R8 no strobe in standby", vcount - v0, 0);
        chk(in_standby == 1, "R9 frame does not wake", in_standby, 1);
        pulse_req();
        idle(159);
        chk(in_standby == 1, "R9 one tick early", in_standby, 1);
        idle(1);
        chk(in_standby == 0, "R9 wake at 160", in_standby, 0);

        // R9 9-bit idle time
        nine_bit = 1'b1;
        pulse_req();
        idle(175);
        chk(in_standby == 1, "R9 nine early", in_standby, 1);
        idle(1);
        chk(in_standby == 0, "R9 nine wake at 176", in_standby, 0);

        // R10 address-mark wakeup, 8-bit
        nine_bit = 1'b0;
        wake_sel = 1'b1;
        pulse_req();
        idle(200);
        chk(in_standby == 1, "R10 idle ignored", in_standby, 1);
        v0 = vcount;
        send_frame(1'b0, 9'h07F, 1'b1, 15);
        chk(vcount == v0 && in_standby == 1, "R10 no mark", vcount - v0, 0);
        send_frame(1'b0, 9'h080, 1'b1, 15);
        chk(vcount == v0 + 1 && v_data == 9'h080, "R10 mark delivered", v_data, 9'h080);
        chk(in_standby == 0, "R10 woke", in_standby, 0);

        // R10 9-bit mark uses bit 8
        nine_bit = 1'b1;
        pulse_req();
        v0 = vcount;
        send_frame(1'b1, 9'h0FF, 1'b1, 15);
        chk(vcount == v0 && in_standby == 1, "R10 nine no mark", vcount - v0, 0);
        send_frame(1'b1, 9'h100, 1'b1, 15);
        chk(vcount == v0 + 1 && v_data == 9'h100 && in_standby == 0,
            "R10 nine mark", v_data, 9'h100);

        // R11 smart-card mode
        nine_bit = 1'b0;
        @(negedge clk);
        smartcard_en = 1'b1;
        pulse_req();
        chk(in_standby == 0, "R11 request ignored", in_standby, 0);
        v0 = vcount;
        send_frame(1'b0, 9'h033, 1'b1, 15);
        chk(vcount == v0 + 1 && v_data == 9'h033, "R11 normal delivery", v_data, 9'h033);
        @(negedge clk);
        smartcard_en = 1'b0;
        pulse_req();
        chk(in_standby == 1, "R11 standby before mode", in_standby, 1);
        smartcard_en = 1'b1;
        @(negedge clk);
        chk(in_standby == 0, "R11 standby cleared", in_standby, 0);
        smartcard_en = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule